// File: doc/BRIEF.md
# Decimal Restoring Division Unit

This unit divides a signed decimal (BCD) dividend by a signed BCD divisor. It builds each quotient digit the way a person does long division. It subtracts the divisor again and again at one digit position and counts each subtraction that does not go below zero. When a subtraction overdraws, one correction step adds the divisor back, the count becomes the quotient digit, and work moves one decimal place to the right. The unit finishes after the last quotient digit, when the divisor's units digit lines up with the least significant dividend digit. What is left in the working window is the remainder.

The caller presents the dividend digits, the divisor digits, both signs, a quotient length and a one-cycle start strobe. The unit works on a window one digit wider than the divisor. The extra high digit absorbs the overdraw. The quotient length sets where the divisor is first aligned, and dividend digits above that alignment take no part in the result. When a quotient digit would need more than nine subtractions, the divisor was placed too far left. The unit then stops and raises arithmetic check in place of a result. A zero divisor ends the same way.

Top module: `dec_div_unit`

## Requirements
- R1: With k the effective quotient length, D the divisor value and V the dividend value taken from its low k+DW digits (DW = divisor digits), a completed division gives quotient V div D in the low k digits of the quotient output, with all higher digits zero. The remainder output holds V mod D in DW digits. Digit i of any vector occupies bits [4i+3:4i], and digit 0 is least significant.
- R2: Dividend digits at positions k+DW and above have no effect on any output.
- R3: The quotient sign (1 = negative) is the XOR of the dividend and divisor signs. The remainder sign equals the dividend sign.
- R4: On normal completion the positive indicator is 1 exactly when the quotient is nonzero and its sign is 0. The zero indicator is 1 exactly when the quotient is zero, whatever its sign.
- R5: If the dividend's top k+DW digits divided by 10^(k-1) reach ten times D or more, arithmetic check is 1, the field-mark output is 0, and both indicators are 0. The operation ends after exactly ten subtraction cycles.
- R6: A divisor of zero always ends with arithmetic check set.
- R7: On normal completion the field-mark output is 1, which records that the first quotient digit was stored.
- R8: The quotient length input is clamped: values below 2 act as 2, and values above QMAX act as QMAX.
- R9: Counting clock edges from the one that accepts start, done rises after (sum of quotient digits) + 2k edges on normal completion. Done is high for exactly one cycle.
- R10: Busy is high from the edge that accepts start until the edge that raises done. A start pulse while busy is ignored and does not change the running division's results.
- R11: After reset, done, busy, arithmetic check, both indicators, the field mark and the quotient are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| dvd_i | input | 4*(QMAX+DLEN) | Dividend BCD digits |
| dvd_neg_i | input | 1 | Dividend sign, 1 = negative |
| dvs_i | input | 4*DLEN | Divisor BCD digits |
| dvs_neg_i | input | 1 | Divisor sign, 1 = negative |
| qlen_i | input | $clog2(QMAX+1) | Requested quotient length |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | 4*QMAX | Quotient digits |
| rem_o | output | 4*DLEN | Remainder digits |
| quo_neg_o | output | 1 | Quotient sign |
| rem_neg_o | output | 1 | Remainder sign |
| mark_o | output | 1 | Field mark on first quotient digit |
| pos_o | output | 1 | Positive nonzero quotient indicator |
| zero_o | output | 1 | Zero quotient indicator |
| arith_chk_o | output | 1 | Arithmetic check (digit overflow) |

## Verification
An ignored start strobe can land on the same clock edge as an add-back-and-shift step of the running division. The bench provokes this by pulsing start with different operands on the second edge after acceptance. In the first scenario that edge is the correction step of the first quotient digit. The bench judges the result by checking that the quotient, remainder, signs and cycle count all still match the first operands. A second coincidence is the tenth successful subtraction, which decides overflow and raises done on the same edge. The bench judges that case by the exact ten-cycle latency together with arithmetic check set and the field mark clear.

// File: rtl/dec_div_pkg.sv
package dec_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUB  = 2'd1,
    ST_ADD  = 2'd2
  } dd_state_e;

  // one BCD digit plus carry in; returns {carry_out, digit}
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] a,
                                               input logic [3:0] b,
                                               input logic       cin);
    logic [4:0] s;
    logic [4:0] t;
    s = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
    t = s - 5'd10;
    if (s >= 5'd10) return {1'b1, t[3:0]};
    else            return {1'b0, s[3:0]};
  endfunction

  function automatic logic [3:0] nines_comp(input logic [3:0] d);
    return 4'd9 - d;
  endfunction

endpackage

// File: rtl/dec_div_alu.sv
module dec_div_alu
  import dec_div_pkg::*;
#(
  parameter int ND = 4
) (
  input  logic [4*ND-1:0] a_i,
  input  logic [4*ND-1:0] b_i,
  input  logic            sub_i,
  output logic [4*ND-1:0] y_o,
  output logic            cout_o
);

  logic       carry;
  logic [4:0] dsum;
  logic [3:0] bop;

  // ten's complement subtract when sub_i: a + nines(b) + 1
  always_comb begin
    carry = sub_i;
    dsum  = '0;
    bop   = '0;
    y_o   = '0;
    for (int i = 0; i < ND; i++) begin
      bop   = sub_i ? nines_comp(b_i[4*i +: 4]) : b_i[4*i +: 4];
      dsum  = bcd_digit_add(a_i[4*i +: 4], bop, carry);
      y_o[4*i +: 4] = dsum[3:0];
      carry = dsum[4];
    end
    cout_o = carry;
  end

endmodule

// File: rtl/dec_div_ctrl.sv
module dec_div_ctrl
  import dec_div_pkg::*;
#(
  parameter int QMAX = 6,
  localparam int JW  = $clog2(QMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [JW-1:0] qlen_i,
  input  logic          dvd_neg_i,
  input  logic          dvs_neg_i,
  input  logic          dvs_zero_i,
  input  logic          borrow_i,
  input  logic          quo_zero_i,
  output logic          ld_o,
  output logic          alu_sub_o,
  output logic          keep_o,
  output logic          add_o,
  output logic          last_o,
  output logic [3:0]    cnt_o,
  output logic [JW-1:0] j_o,
  output logic [JW-1:0] k_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          qneg_o,
  output logic          rneg_o,
  output logic          mark_o,
  output logic          pos_o,
  output logic          zero_o,
  output logic          ovf_o
);

  dd_state_e     st_q;
  logic [3:0]    cnt_q;
  logic [JW-1:0] j_q, k_q;
  logic          qneg_q, rneg_q, mark_q, pos_q, zero_q, ovf_q, done_q;
  logic          dvs0_q;

  // named events for assertions
  logic sub_ok, digit_ovf, quo_is_zero;

  function automatic logic [JW-1:0] clamp_len(input logic [JW-1:0] q);
    if (q < JW'(2))         return JW'(2);
    else if (q > JW'(QMAX)) return JW'(QMAX);
    else                    return q;
  endfunction

  assign k_o         = clamp_len(qlen_i);
  assign ld_o        = (st_q == ST_IDLE) && start_i;
  assign alu_sub_o   = (st_q == ST_SUB);
  assign sub_ok      = (st_q == ST_SUB) && !borrow_i;
  assign digit_ovf   = sub_ok && (cnt_q == 4'd9);
  assign keep_o      = (st_q == ST_SUB) && !digit_ovf;
  assign add_o       = (st_q == ST_ADD);
  assign last_o      = (j_q == '0);
  assign cnt_o       = cnt_q;
  assign j_o         = j_q;
  assign quo_is_zero = quo_zero_i && (cnt_q == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      j_q    <= '0;
      k_q    <= JW'(2);
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      mark_q <= 1'b0;
      pos_q  <= 1'b0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
      dvs0_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_SUB;
            cnt_q  <= '0;
            j_q    <= k_o - JW'(1);
            k_q    <= k_o;
            qneg_q <= dvd_neg_i ^ dvs_neg_i;
            rneg_q <= dvd_neg_i;
            mark_q <= 1'b0;
            pos_q  <= 1'b0;
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
            dvs0_q <= dvs_zero_i;
          end
        end
        ST_SUB: begin
          if (borrow_i) begin
            st_q <= ST_ADD;
          end else if (digit_ovf) begin
            ovf_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_ADD: begin
          mark_q <= 1'b1;
          cnt_q  <= '0;
          if (last_o) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
            zero_q <= quo_is_zero;
            pos_q  <= !qneg_q && !quo_is_zero;
          end else begin
            j_q  <= j_q - JW'(1);
            st_q <= ST_SUB;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign qneg_o = qneg_q;
  assign rneg_o = rneg_q;
  assign mark_o = mark_q;
  assign pos_o  = pos_q;
  assign zero_o = zero_q;
  assign ovf_o  = ovf_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(k_q) && $stable(rneg_q));

  // R5
  ovf_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ovf_q) |-> !mark_q && !pos_q && !zero_q);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUB) |-> (cnt_q <= 4'd9));

  // R4
  ind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !(pos_q && zero_q) && !(pos_q && qneg_q));

  // R6
  zero_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs0_q) |-> ovf_q);

endmodule

// File: rtl/dec_div_path.sv
module dec_div_path
  import dec_div_pkg::*;
#(
  parameter int QMAX = 6,
  parameter int DLEN = 3,
  localparam int JW  = $clog2(QMAX + 1),
  localparam int WD  = DLEN + 1,
  localparam int NDV = QMAX + DLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [JW-1:0]     k_i,
  input  logic [4*NDV-1:0]  dvd_i,
  input  logic [4*DLEN-1:0] dvs_i,
  input  logic              alu_sub_i,
  input  logic              keep_i,
  input  logic              add_i,
  input  logic              last_i,
  input  logic [3:0]        cnt_i,
  input  logic [JW-1:0]     j_i,
  output logic              borrow_o,
  output logic              quo_zero_o,
  output logic [4*QMAX-1:0] quo_o,
  output logic [4*DLEN-1:0] rem_o
);

  logic [4*WD-1:0]   win_q;
  logic [4*DLEN-1:0] dvs_q;
  logic [4*NDV-1:0]  dvd_q;
  logic [4*QMAX-1:0] quo_q;

  logic [4*WD-1:0]   alu_y;
  logic              alu_c;
  logic [4*NDV-1:0]  init_sh, next_sh;
  logic [JW-1:0]     km1, jm1;
  logic [4*WD-1:0]   win_init;
  logic [3:0]        next_dig;
  logic [3:0]        restored_top;

  dec_div_alu #(.ND(WD)) u_alu (
    .a_i   (win_q),
    .b_i   ({4'h0, dvs_q}),
    .sub_i (alu_sub_i),
    .y_o   (alu_y),
    .cout_o(alu_c)
  );

  assign borrow_o = alu_sub_i && !alu_c;

  // divisor units digit first sits at dividend position k-1
  assign km1      = k_i - JW'(1);
  assign init_sh  = dvd_i >> {km1, 2'b00};
  assign win_init = init_sh[4*WD-1:0];

  assign jm1      = j_i - JW'(1);
  assign next_sh  = dvd_q >> {jm1, 2'b00};
  assign next_dig = next_sh[3:0];

  assign restored_top = alu_y[4*WD-1 -: 4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
      quo_q <= '0;
    end else if (ld_i) begin
      win_q <= win_init;
      dvs_q <= dvs_i;
      dvd_q <= dvd_i;
      quo_q <= '0;
    end else if (keep_i) begin
      win_q <= alu_y;
    end else if (add_i) begin
      quo_q <= {quo_q[4*QMAX-5:0], cnt_i};
      win_q <= last_i ? alu_y : {alu_y[4*DLEN-1:0], next_dig};
    end
  end

  assign quo_zero_o = (quo_q == '0);
  assign quo_o      = quo_q;
  assign rem_o      = win_q[4*DLEN-1:0];

  // R1
  add_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_i |-> (restored_top == 4'd0));

endmodule

// File: rtl/dec_div_unit.sv
module dec_div_unit #(
  parameter int QMAX = 6,
  parameter int DLEN = 3,
  localparam int JW  = $clog2(QMAX + 1),
  localparam int NDV = QMAX + DLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4*NDV-1:0]  dvd_i,
  input  logic              dvd_neg_i,
  input  logic [4*DLEN-1:0] dvs_i,
  input  logic              dvs_neg_i,
  input  logic [JW-1:0]     qlen_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [4*QMAX-1:0] quo_o,
  output logic [4*DLEN-1:0] rem_o,
  output logic              quo_neg_o,
  output logic              rem_neg_o,
  output logic              mark_o,
  output logic              pos_o,
  output logic              zero_o,
  output logic              arith_chk_o
);

  logic          ld, alu_sub, keep, add_step, last;
  logic          borrow, quo_zero;
  logic [3:0]    cnt;
  logic [JW-1:0] j_idx, k_len;
  logic          dvs_zero;

  assign dvs_zero = (dvs_i == '0);

  dec_div_ctrl #(.QMAX(QMAX)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .qlen_i    (qlen_i),
    .dvd_neg_i (dvd_neg_i),
    .dvs_neg_i (dvs_neg_i),
    .dvs_zero_i(dvs_zero),
    .borrow_i  (borrow),
    .quo_zero_i(quo_zero),
    .ld_o      (ld),
    .alu_sub_o (alu_sub),
    .keep_o    (keep),
    .add_o     (add_step),
    .last_o    (last),
    .cnt_o     (cnt),
    .j_o       (j_idx),
    .k_o       (k_len),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .qneg_o    (quo_neg_o),
    .rneg_o    (rem_neg_o),
    .mark_o    (mark_o),
    .pos_o     (pos_o),
    .zero_o    (zero_o),
    .ovf_o     (arith_chk_o)
  );

  dec_div_path #(.QMAX(QMAX), .DLEN(DLEN)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (ld),
    .k_i       (k_len),
    .dvd_i     (dvd_i),
    .dvs_i     (dvs_i),
    .alu_sub_i (alu_sub),
    .keep_i    (keep),
    .add_i     (add_step),
    .last_i    (last),
    .cnt_i     (cnt),
    .j_i       (j_idx),
    .borrow_o  (borrow),
    .quo_zero_o(quo_zero),
    .quo_o     (quo_o),
    .rem_o     (rem_o)
  );

  // R3
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(quo_neg_o) && $stable(rem_neg_o));

endmodule

// File: tb/tb_dec_div_unit.sv
`timescale 1ns/1ps
module tb_dec_div_unit;
  localparam int QMAX = 6;
  localparam int DLEN = 3;
  localparam int JW   = $clog2(QMAX + 1);
  localparam int NDV  = QMAX + DLEN;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [4*NDV-1:0]  dvd_i = '0;
  logic              dvd_neg_i = 1'b0;
  logic [4*DLEN-1:0] dvs_i = '0;
  logic              dvs_neg_i = 1'b0;
  logic [JW-1:0]     qlen_i = '0;
  logic              busy_o, done_o, quo_neg_o, rem_neg_o, mark_o, pos_o, zero_o, arith_chk_o;
  logic [4*QMAX-1:0] quo_o;
  logic [4*DLEN-1:0] rem_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dec_div_unit #(.QMAX(QMAX), .DLEN(DLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dvd_i(dvd_i), .dvd_neg_i(dvd_neg_i),
    .dvs_i(dvs_i), .dvs_neg_i(dvs_neg_i), .qlen_i(qlen_i), .busy_o(busy_o),
    .done_o(done_o), .quo_o(quo_o), .rem_o(rem_o), .quo_neg_o(quo_neg_o),
    .rem_neg_o(rem_neg_o), .mark_o(mark_o), .pos_o(pos_o), .zero_o(zero_o),
    .arith_chk_o(arith_chk_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint p10(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic longint from_bcd(input logic [4*NDV-1:0] v, input int nd);
    longint r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [4*NDV-1:0] to_bcd(input longint v);
    logic [4*NDV-1:0] r = '0;
    longint t = v;
    for (int i = 0; i < NDV; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // scenario: divide and check everything against an arithmetic model
  task automatic run_case(input string name, input longint dvd, input bit dneg,
                          input longint dvs, input bit sneg, input int qlen, input bit poke);
    int k, cyc, exp_lat;
    longint v, w0, q, r, t;
    bit ovf;
    logic [4*NDV-1:0] dv_full;
    k = (qlen < 2) ? 2 : ((qlen > QMAX) ? QMAX : qlen);
    v = dvd % p10(k + DLEN);
    w0 = v / p10(k - 1);
    ovf = (w0 >= 10 * dvs);
    q = ovf ? 0 : v / dvs;
    r = ovf ? 0 : v % dvs;
    exp_lat = ovf ? 10 : 2 * k;
    t = q;
    while (t > 0) begin exp_lat += int'(t % 10); t = t / 10; end

    @(negedge clk);
    dvd_i = to_bcd(dvd); dvd_neg_i = dneg;
    dv_full = to_bcd(dvs);
    dvs_i = dv_full[4*DLEN-1:0]; dvs_neg_i = sneg;
    qlen_i = JW'(qlen);
    start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) begin
        chk(busy_o == 1'b1, {"R10 busy ", name}, busy_o, 1);
        if (poke) begin
          dvd_i = to_bcd(64'd777777); dvd_neg_i = ~dneg; dvs_i = 12'h001; qlen_i = JW'(2);
          start_i = 1'b1;
        end
      end
      if (cyc == 2) start_i = 1'b0;
      if (done_o) break;
      if (cyc > 300) begin chk(1'b0, {"R9 timeout ", name}, cyc, exp_lat); return; end
    end
    chk(cyc == exp_lat, {"R9 latency ", name}, cyc, exp_lat);
    chk(busy_o == 1'b0, {"R10 idle at done ", name}, busy_o, 0);
    chk(arith_chk_o == ovf, {"R5 arith check ", name}, arith_chk_o, ovf);
    chk(mark_o == !ovf, {"R7 field mark ", name}, mark_o, !ovf);
    if (!ovf) begin
      chk(from_bcd({{4*DLEN{1'b0}}, quo_o}, QMAX) == q, {"R1 quotient ", name},
          from_bcd({{4*DLEN{1'b0}}, quo_o}, QMAX), q);
      chk(from_bcd({{4*QMAX{1'b0}}, rem_o}, DLEN) == r, {"R1 remainder ", name},
          from_bcd({{4*QMAX{1'b0}}, rem_o}, DLEN), r);
      chk(quo_neg_o == (dneg ^ sneg), {"R3 quotient sign ", name}, quo_neg_o, dneg ^ sneg);
      chk(rem_neg_o == dneg, {"R3 remainder sign ", name}, rem_neg_o, dneg);
      chk(pos_o == (q != 0 && !(dneg ^ sneg)), {"R4 positive ", name}, pos_o, (q != 0 && !(dneg ^ sneg)));
      chk(zero_o == (q == 0), {"R4 zero ", name}, zero_o, (q == 0));
    end else begin
      chk(!pos_o && !zero_o, {"R5 indicators clear ", name}, {pos_o, zero_o}, 0);
    end
    @(negedge clk);
    chk(done_o == 1'b0, {"R9 done one cycle ", name}, done_o, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({done_o, busy_o, arith_chk_o, pos_o, zero_o, mark_o} == 6'b0, "R11 reset flags",
        {done_o, busy_o, arith_chk_o, pos_o, zero_o, mark_o}, 0);
    chk(quo_o == '0, "R11 reset quotient", quo_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_ignored_high();
    longint q_a, q_b;
    run_case("R2 low digits only", 54321, 1'b0, 999, 1'b0, 2, 1'b0);
    q_a = from_bcd({{4*DLEN{1'b0}}, quo_o}, QMAX);
    run_case("R2 high digits set", 987654321, 1'b0, 999, 1'b0, 2, 1'b0);
    q_b = from_bcd({{4*DLEN{1'b0}}, quo_o}, QMAX);
    chk(q_a == q_b, "R2 high dividend digits ignored", q_b, q_a);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    run_case("basic 4906/23", 4906, 1'b0, 23, 1'b0, 4, 1'b0);
    run_case("neg dividend", 21200, 1'b1, 24, 1'b0, 5, 1'b0);
    run_case("both negative", 21200, 1'b1, 24, 1'b1, 5, 1'b0);
    run_case("zero quotient", 5, 1'b0, 7, 1'b0, 2, 1'b0);
    run_case("zero quotient neg", 5, 1'b0, 7, 1'b1, 2, 1'b0);
    run_case("R5 overflow", 21200, 1'b0, 21, 1'b0, 3, 1'b0);
    run_case("R6 zero divisor", 123, 1'b0, 0, 1'b0, 3, 1'b0);
    run_case("R8 qlen low clamp", 99, 1'b0, 1, 1'b0, 0, 1'b0);
    run_case("R8 qlen high clamp", 123456, 1'b0, 5, 1'b1, 7, 1'b0);
    run_case("max divisor", 999998, 1'b0, 999, 1'b0, 3, 1'b0);
    run_case("R10 start while busy", 4906, 1'b0, 23, 1'b0, 4, 1'b1);
    t_ignored_high();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule